// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from reset until the memory is ready for ordinary traffic. After reset is released it first sits idle for a long settling interval. The interval is counted in clock cycles and is meant to cover the 200 µs that the memory needs once supply and clock are steady. It then closes every bank with a precharge-all and lets the row precharge time pass. Next it issues a burst of auto-refresh commands, each separated by the refresh cycle time. Last, it loads the mode register from a supplied value, waits out the mode-register delay and raises `init_done`.

Clock enable and all data-mask lines stay high for the whole run, so the memory's data drivers stay in high impedance. Every cycle that does not carry one of the four initialization commands carries a NOP. All intervals and the refresh count are parameters. A refresh count below eight is raised to eight. The controller that follows waits for `init_done` before it takes over the pins.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, the command pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), the address bus is zero and init_done is low.
- R2: The first non-NOP command after reset release is precharge-all ({cs_n,ras_n,cas_n,we_n} = 4'b0010) with address bit AP_BIT high and the other address bits zero. It is driven in the T_STABLE-th cycle after release.
- R3: The first auto-refresh ({cs_n,ras_n,cas_n,we_n} = 4'b0001, address zero) is driven exactly T_RP cycles after the precharge-all.
- R4: Exactly N_REF auto-refresh commands are issued (at least 8), each one T_RC cycles after the previous one.
- R5: Mode-register-set ({cs_n,ras_n,cas_n,we_n} = 4'b0000) is driven exactly once, T_RC cycles after the last refresh. Its address bus equals mode_val as sampled at the issuing clock edge.
- R6: init_done rises exactly T_MRD cycles after mode-register-set. It then stays high, and the command pins stay NOP until reset.
- R7: cke is high and every dqm bit is high in every cycle, including during reset.
- R8: Every cycle that carries none of the commands above is a NOP with the address bus zero.
- R9: Asserting reset at any point, including in a command cycle or after init_done, restarts the whole sequence from the settling wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_val | input | ADDR_W | Value placed on the address bus by mode-register-set |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| dqm | output | DQM_W | Data mask, held high |
| init_done | output | 1 | High once the sequence has completed |

## Verification
Two events can meet in one cycle. The recovery countdown after a refresh can expire in the same cycle that the refresh tally reaches zero, and the sequencer must then choose mode-register-set over another refresh. Reset can also arrive in the very cycle that a command is driven. The bench compares every cycle against a schedule computed from the parameters, so an extra or missing refresh at the tally boundary shows up as a wrong command code in a known cycle. Reset is dropped directly on the precharge-all cycle, on the mode-register-set cycle, on the cycle before init_done and at random points. After each of these the whole schedule is expected again from its start.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int ADDR_W   = 13,
  parameter int DQM_W    = 2,
  parameter int AP_BIT   = 10,
  parameter int T_STABLE = 40000,
  parameter int T_RP     = 3,
  parameter int T_RC     = 9,
  parameter int T_MRD    = 2,
  parameter int N_REF    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_val,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DQM_W-1:0]  dqm,
  output logic              init_done
);
  localparam int REF_N = (N_REF < 8) ? 8 : N_REF;
  localparam int MAX_A = (T_STABLE > T_RP) ? T_STABLE : T_RP;
  localparam int MAX_B = (T_RC > T_MRD) ? T_RC : T_MRD;
  localparam int MAXW  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXW + 1);
  localparam int RW    = $clog2(REF_N + 1);

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  typedef enum logic [2:0] {PH_STABLE, PH_PRE, PH_REF, PH_MRS, PH_DONE} phase_t;

  phase_t            phase;
  logic [CW-1:0]     cnt;
  logic [RW-1:0]     ref_left;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;

  assign cke       = 1'b1;
  assign dqm       = '1;
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr      = addr_q;
  assign init_done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_STABLE;
      cnt      <= CW'(T_STABLE - 1);
      ref_left <= '0;
      cmd_q    <= CMD_NOP;
      addr_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (phase)
          PH_STABLE: begin
            cmd_q          <= CMD_PRE;
            addr_q[AP_BIT] <= 1'b1;
            cnt            <= CW'(T_RP - 1);
            phase          <= PH_PRE;
          end
          PH_PRE: begin
            cmd_q    <= CMD_REF;
            cnt      <= CW'(T_RC - 1);
            ref_left <= RW'(REF_N - 1);
            phase    <= PH_REF;
          end
          PH_REF: begin
            if (ref_left != '0) begin
              cmd_q    <= CMD_REF;
              cnt      <= CW'(T_RC - 1);
              ref_left <= ref_left - 1'b1;
            end else begin
              cmd_q  <= CMD_MRS;
              addr_q <= mode_val;
              cnt    <= CW'(T_MRD - 1);
              phase  <= PH_MRS;
            end
          end
          PH_MRS: begin
            done_q <= 1'b1;
            phase  <= PH_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assert_pre_ap_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> (addr_q[AP_BIT] && phase == PH_PRE));

  assert_mrs_after_last_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS) |-> (ref_left == '0 && phase == PH_MRS));

  assert_mrs_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS) |=> (cmd_q != CMD_MRS));

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);

  assert_nop_when_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cmd_q == CMD_NOP));

  assert_nop_addr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_NOP) |-> (addr_q == '0));
endmodule

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/100ps
module sdram_init_seq_bench;
  localparam int AW = 13, DW = 2, APB = 10;
  localparam int TS = 200, TRP = 3, TRC = 7, TMRD = 2, NR = 8;
  localparam int K_PRE  = TS;
  localparam int K_REF0 = TS + TRP;
  localparam int K_MRS  = K_REF0 + NR * TRC;
  localparam int K_DONE = K_MRS + TMRD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mode_val = '0;
  logic          cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [AW-1:0] addr;
  logic [DW-1:0] dqm;

  int n_chk = 0, n_fail = 0, k = 0, ref_seen = 0;
  bit restarted = 0;

  always #2.5 clk = ~clk;

  sdram_init_seq #(.ADDR_W(AW), .DQM_W(DW), .AP_BIT(APB), .T_STABLE(TS),
                   .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .N_REF(NR)) u_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .mode_val(mode_val), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .dqm(dqm),
    .init_done(init_done));

  function automatic logic [3:0] exp_cmd(int kk);
    if (kk == K_PRE) return 4'b0010;
    if (kk >= K_REF0 && kk < K_MRS && ((kk - K_REF0) % TRC) == 0) return 4'b0001;
    if (kk == K_MRS) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic string exp_tag(int kk);
    if (kk == K_PRE) return "R2";
    if (kk == K_REF0) return "R3";
    if (kk > K_REF0 && kk < K_MRS) return "R4";
    if (kk == K_MRS) return "R5";
    if (kk >= K_DONE) return "R6";
    return "R8";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s k=%0d actual=%0h expected=%0h", tag, k, act, expv);
    end
  endtask

  task automatic tick(logic next_rst);
    logic [3:0]    ec;
    logic [AW-1:0] ea;
    string         t;
    @(negedge clk);
    chk("R7", {31'd0, cke & (&dqm)}, 32'd1);
    if (!rst_n) begin
      k = 0;
      ref_seen = 0;
      chk("R1", {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, 4'b0111});
      chk("R1", {19'd0, addr}, 32'd0);
      chk("R1", {31'd0, init_done}, 32'd0);
    end else begin
      k++;
      ec = exp_cmd(k);
      ea = '0;
      if (ec == 4'b0010) ea[APB] = 1'b1;
      if (ec == 4'b0000) ea = mode_val;
      if (cs_n == 1'b0 && ras_n == 1'b0 && cas_n == 1'b0 && we_n == 1'b1) ref_seen++;
      t = restarted ? {"R9/", exp_tag(k)} : exp_tag(k);
      chk(t, {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, ec});
      chk(t, {19'd0, addr}, {19'd0, ea});
      chk(k >= K_DONE ? t : "R6", {31'd0, init_done}, {31'd0, k >= K_DONE});
      if (k == K_DONE) chk("R4", ref_seen, NR);
    end
    rst_n = next_rst;
    mode_val = AW'($urandom);
  endtask

  task automatic run_to(int cycles);
    for (int i = 0; i < cycles; i++) tick(1'b1);
  endtask

  task automatic hit_reset(int at);
    run_to(at);
    tick(1'b0);
    tick(1'b0);
    restarted = 1;
  endtask

  initial begin
    int r;
    void'($urandom(32'h5eed_1234));
    tick(1'b0);
    tick(1'b0);
    tick(1'b1);
    run_to(K_DONE + 20);
    hit_reset(0);
    hit_reset(K_PRE);
    hit_reset(K_MRS);
    hit_reset(K_DONE - 1);
    for (int j = 0; j < 4; j++) begin
      r = $urandom_range(1, K_DONE + 5);
      hit_reset(r);
    end
    run_to(K_DONE + 30);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired k=%0d actual=running expected=finished", k);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule